// File: doc/BRIEF.md
# Diagnostic Status Latch Unit

This block sits between the raw fault comparators of a multi-output driver and the status registers read by a host. It takes per-channel open-load indications and four shared supply and thermal indications. Each one is qualified by a persistence filter, and a qualified fault is turned into a sticky status flag. From these flags and the live filtered supply condition, the block decides whether every power output must be held off.

Each fault class follows its own policy. Open-load and temperature warning are reported only. Thermal shutdown holds every output off until the host clears it, and that clear is refused while the hot condition is still present. A supply over- or under-voltage holds the outputs off only while the filtered condition lasts, unless the host has asked for manual recovery. In that case the outputs stay off until the flag is cleared. After the device leaves standby, a not-ready flag and a forced-off state cover a settling interval. A single summary bit reports that nothing at all is flagged.

The filter and settling durations are parameters counted in clock cycles. A host clear arrives as a one-cycle strobe at the end of a serial frame. The serial framing and the analog comparators are outside this block.

Top module: `diag_status_unit`

## Requirements
- R1: A shared fault flag (over-voltage, under-voltage, temperature warning, thermal shutdown) sets at the clock edge where its raw input has been sampled high on FAST_CYC consecutive edges. Any edge sampling the raw input low restarts the count, so a shorter pulse leaves the flag at 0.
- R2: Each open-load flag ol_flag[i] follows the same rule with SLOW_CYC consecutive edges, independently per channel.
- R3: Open-load and temperature-warning flags never cause drv_off to be high.
- R4: While tsd_flag is 1, drv_off is 1. A clear strobe sampled while raw_tsd is high leaves tsd_flag (and tw_flag, under the same rule with raw_tw) set. A clear strobe sampled with the raw input low clears it.
- R5: With rcv_dis at 0, drv_off is 1 from the edge where over- or under-voltage qualifies until the first edge that samples both raw_ov and raw_uv low. The ov_flag and uv_flag flags stay set after that.
- R6: With rcv_dis at 1, drv_off stays 1 as long as ov_flag or uv_flag is set, and it releases only after a clear strobe.
- R7: A clear strobe resets every flag at the next edge. If a flag qualifies on that same edge, setting wins and the flag stays 1.
- R8: While active is 0, drv_off is 1. The next edge resets all flags, all filter counts and not_ready.
- R9: When active is first sampled high after being low (or after reset), not_ready is 1 for exactly SETTLE_CYC cycles and then clears by itself. drv_off is 1 throughout.
- R10: no_err is 1 exactly when no fault flag and not_ready are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active | input | 1 | 1 = operating, 0 = standby |
| clr_stb | input | 1 | One-cycle host clear strobe (end of frame) |
| rcv_dis | input | 1 | 1 = supply faults need a host clear before outputs return |
| raw_ol | input | NCH | Raw open-load comparator per channel |
| raw_ov | input | 1 | Raw supply over-voltage comparator |
| raw_uv | input | 1 | Raw supply under-voltage comparator |
| raw_tw | input | 1 | Raw temperature-warning comparator |
| raw_tsd | input | 1 | Raw thermal-shutdown comparator |
| ol_flag | output | NCH | Latched open-load flags |
| ov_flag | output | 1 | Latched over-voltage flag |
| uv_flag | output | 1 | Latched under-voltage flag |
| tw_flag | output | 1 | Latched temperature-warning flag |
| tsd_flag | output | 1 | Latched thermal-shutdown flag |
| not_ready | output | 1 | Settling interval after leaving standby |
| no_err | output | 1 | 1 when nothing is flagged |
| drv_off | output | 1 | 1 = all power outputs must be off |

## Verification
The key collision is a host clear strobe that lands on the same edge where a filter reaches its threshold. The clear must lose, so the flag stays set. The bench provokes this directly by raising raw_ov for FAST_CYC-1 edges and then pulsing clr_stb on the qualifying edge. Long random runs also produce such collisions by chance, together with clears that arrive while thermal inputs are still raw-high. A cycle model built from the requirements judges every cycle, and explicit checks confirm the directed outcomes.

// File: rtl/diag_pkg.sv
`timescale 1ns/1ps
// Package: shared indices and policy helpers for the diagnostic status unit.
// Assumes the four shared fault inputs are packed in the order given below.
package diag_pkg;
    localparam int IDX_OV   = 0;
    localparam int IDX_UV   = 1;
    localparam int IDX_TW   = 2;
    localparam int IDX_TSD  = 3;
    localparam int NUM_FAST = 4;

    // Clear is refused while the raw condition persists for thermal faults.
    function automatic bit hold_on_raw(input int idx);
        return (idx == IDX_TW) || (idx == IDX_TSD);
    endfunction
endpackage

// File: rtl/diag_filter.sv
`timescale 1ns/1ps
// Module: diag_filter
// Persistence filter. qual is high while raw has been sampled high on at
// least LIM consecutive edges, counting the current cycle's edge-to-be.
// Assumes LIM >= 1. The count restarts whenever raw is sampled low or en is low.
module diag_filter #(
    parameter int LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic qual
);
    localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIM - 1);

    logic [CW-1:0] cnt;

    // Combinational qualification: saturated count and raw still present.
    assign qual = en && raw && (cnt == TOP);

    // Count consecutive raw-high edges, saturating one below the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !raw) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    generate
        if (LIM > 1) begin : g_chk
            rise_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(qual) |-> $past(raw))
                else $error("qualification without prior raw sample");
        end
    endgenerate
endmodule

// File: rtl/diag_latch.sv
`timescale 1ns/1ps
// Module: diag_latch
// Sticky status flag. set has priority over clr. With HOLD set, a clear is
// ignored while raw is high. en low forces the flag to zero at the next edge.
module diag_latch #(
    parameter bit HOLD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    input  logic raw,
    output logic stat
);
    logic clr_ok;

    // A clear takes effect unless the hold policy blocks it.
    assign clr_ok = clr && !(HOLD && raw);

    // Latch the flag: set wins, then an accepted clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            stat <= 1'b0;
        end else begin
            stat <= set || (stat && !clr_ok);
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set && en) |=> stat)
        else $error("flag failed to set on qualification");

    // R4
    generate
        if (HOLD) begin : g_hold
            hold_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (stat && raw && en) |=> stat)
                else $error("flag cleared while raw condition present");
        end
    endgenerate
endmodule

// File: rtl/diag_settle.sv
`timescale 1ns/1ps
// Module: diag_settle
// Start-up settling timer. When active is sampled high after being low,
// nrdy is high for exactly SETTLE cycles. Assumes SETTLE >= 1.
module diag_settle #(
    parameter int SETTLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic nrdy
);
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] TMR_INIT = SW'(SETTLE - 1);

    logic          act_q;
    logic [SW-1:0] tmr;

    // Track the previous active level to spot the standby exit.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= active;
    end

    // Run the settling countdown and drop nrdy at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            nrdy <= 1'b0;
            tmr  <= '0;
        end else if (!act_q) begin
            nrdy <= 1'b1;
            tmr  <= TMR_INIT;
        end else if (nrdy) begin
            if (tmr == '0) nrdy <= 1'b0;
            else           tmr  <= tmr - 1'b1;
        end
    end

    // R9
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !act_q) |=> nrdy)
        else $error("not-ready missing after standby exit");

    // R9
    expiry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrdy && active && act_q && tmr == '0) |=> !nrdy)
        else $error("not-ready stuck after timer expiry");
endmodule

// File: rtl/diag_status_unit.sv
`timescale 1ns/1ps
// Module: diag_status_unit (top)
// Filters raw fault inputs, latches status flags, applies per-class clear
// and recovery policies and decides the global output-off condition.
// Assumes clr_stb is a single-cycle pulse. All inputs are synchronous to clk.
module diag_status_unit
    import diag_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int FAST_CYC   = 256,
    parameter int SLOW_CYC   = 8000,
    parameter int SETTLE_CYC = 1280
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           clr_stb,
    input  logic           rcv_dis,
    input  logic [NCH-1:0] raw_ol,
    input  logic           raw_ov,
    input  logic           raw_uv,
    input  logic           raw_tw,
    input  logic           raw_tsd,
    output logic [NCH-1:0] ol_flag,
    output logic           ov_flag,
    output logic           uv_flag,
    output logic           tw_flag,
    output logic           tsd_flag,
    output logic           not_ready,
    output logic           no_err,
    output logic           drv_off
);
    logic [NUM_FAST-1:0] f_raw, f_qual, f_flag;
    logic [NCH-1:0]      ol_qual;
    logic [1:0]          sup_live;
    logic                supply_off;

    assign f_raw = {raw_tsd, raw_tw, raw_uv, raw_ov};

    // Shared faults: one filter and one latch each, policy from the package.
    for (genvar i = 0; i < NUM_FAST; i++) begin : g_fast
        diag_filter #(.LIM(FAST_CYC)) u_flt (
            .clk(clk), .rst_n(rst_n), .en(active),
            .raw(f_raw[i]), .qual(f_qual[i])
        );
        diag_latch #(.HOLD(hold_on_raw(i))) u_lat (
            .clk(clk), .rst_n(rst_n), .en(active),
            .set(f_qual[i]), .clr(clr_stb), .raw(f_raw[i]), .stat(f_flag[i])
        );
    end

    // Per-channel open-load: slow filter, report-only latch.
    for (genvar c = 0; c < NCH; c++) begin : g_ol
        diag_filter #(.LIM(SLOW_CYC)) u_flt (
            .clk(clk), .rst_n(rst_n), .en(active),
            .raw(raw_ol[c]), .qual(ol_qual[c])
        );
        diag_latch #(.HOLD(1'b0)) u_lat (
            .clk(clk), .rst_n(rst_n), .en(active),
            .set(ol_qual[c]), .clr(clr_stb), .raw(raw_ol[c]), .stat(ol_flag[c])
        );
    end

    // Live filtered supply condition: set on qualification, drop on raw low.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sup_live <= '0;
        end else begin
            sup_live[0] <= raw_ov && (f_qual[IDX_OV] || sup_live[0]);
            sup_live[1] <= raw_uv && (f_qual[IDX_UV] || sup_live[1]);
        end
    end

    diag_settle #(.SETTLE(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .active(active), .nrdy(not_ready)
    );

    // Supply recovery policy: automatic on live level, or manual on flags.
    assign supply_off = rcv_dis ? (f_flag[IDX_OV] || f_flag[IDX_UV]) : (|sup_live);

    // Global output-off decision and status outputs.
    assign drv_off  = !active || not_ready || f_flag[IDX_TSD] || supply_off;
    assign ov_flag  = f_flag[IDX_OV];
    assign uv_flag  = f_flag[IDX_UV];
    assign tw_flag  = f_flag[IDX_TW];
    assign tsd_flag = f_flag[IDX_TSD];
    assign no_err   = !((|f_flag) || (|ol_flag) || not_ready);

    // R8
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (f_flag == '0 && ol_flag == '0 && !not_ready && sup_live == '0))
        else $error("standby did not clear state");

    // R5
    live_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_ov && !raw_uv) |=> (sup_live == '0))
        else $error("supply condition outlived raw input");
endmodule

// File: tb/diag_status_unit_test.sv
`timescale 1ns/1ps
module diag_status_unit_test;
    localparam int NCH    = 4;
    localparam int FAST   = 4;
    localparam int SLOW   = 12;
    localparam int SETTLE = 6;
    localparam int NF     = NCH + 4;
    localparam int OV = NCH, UV = NCH + 1, TW = NCH + 2, TSD = NCH + 3;

    logic clk = 1'b0;
    logic rst_n, active, clr_stb, rcv_dis;
    logic [NCH-1:0] raw_ol;
    logic raw_ov, raw_uv, raw_tw, raw_tsd;
    logic [NCH-1:0] ol_flag;
    logic ov_flag, uv_flag, tw_flag, tsd_flag, not_ready, no_err, drv_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    diag_status_unit #(.NCH(NCH), .FAST_CYC(FAST), .SLOW_CYC(SLOW), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .active(active), .clr_stb(clr_stb), .rcv_dis(rcv_dis),
        .raw_ol(raw_ol), .raw_ov(raw_ov), .raw_uv(raw_uv), .raw_tw(raw_tw), .raw_tsd(raw_tsd),
        .ol_flag(ol_flag), .ov_flag(ov_flag), .uv_flag(uv_flag), .tw_flag(tw_flag),
        .tsd_flag(tsd_flag), .not_ready(not_ready), .no_err(no_err), .drv_off(drv_off)
    );

    // Requirement model state
    int m_cnt[NF];
    bit m_flag[NF];
    bit m_lvl[NF];
    bit m_nrdy, m_actq;
    int m_tmr;

    function automatic bit raw_of(int i);
        if (i < NCH) return raw_ol[i];
        case (i)
            OV: return raw_ov;
            UV: return raw_uv;
            TW: return raw_tw;
            default: return raw_tsd;
        endcase
    endfunction

    function automatic int lim_of(int i);
        return (i < NCH) ? SLOW : FAST;
    endfunction

    // Model step per edge, following R1, R2, R4, R5, R7, R8, R9
    always @(posedge clk) begin
        if (!rst_n || !active) begin
            for (int i = 0; i < NF; i++) begin
                m_cnt[i] = 0; m_flag[i] = 0; m_lvl[i] = 0;
            end
            m_nrdy = 0; m_tmr = 0;
        end else begin
            for (int i = 0; i < NF; i++) begin
                bit r, q, hold;
                r = raw_of(i);
                q = r && (m_cnt[i] >= lim_of(i) - 1);
                hold = (i == TW || i == TSD) && r;
                m_flag[i] = q || (m_flag[i] && !(clr_stb && !hold));
                m_lvl[i]  = r && (q || m_lvl[i]);
                m_cnt[i]  = r ? ((m_cnt[i] < lim_of(i) - 1) ? m_cnt[i] + 1 : m_cnt[i]) : 0;
            end
            if (!m_actq) begin
                m_nrdy = 1; m_tmr = SETTLE - 1;
            end else if (m_nrdy) begin
                if (m_tmr == 0) m_nrdy = 0; else m_tmr--;
            end
        end
        m_actq = rst_n ? active : 1'b0;
    end

    function automatic bit exp_off();
        bit sup;
        sup = rcv_dis ? (m_flag[OV] || m_flag[UV]) : (m_lvl[OV] || m_lvl[UV]);
        return !active || m_nrdy || m_flag[TSD] || sup;
    endfunction

    function automatic bit exp_no_err();
        bit any;
        any = m_nrdy;
        for (int i = 0; i < NF; i++) any |= m_flag[i];
        return !any;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [NCH-1:0] eol;
        for (int i = 0; i < NCH; i++) eol[i] = m_flag[i];
        chk("R2 ol_flag", ol_flag, eol);
        chk("R1/R7 ov_flag", ov_flag, m_flag[OV]);
        chk("R1/R7 uv_flag", uv_flag, m_flag[UV]);
        chk("R1/R4 tw_flag", tw_flag, m_flag[TW]);
        chk("R1/R4 tsd_flag", tsd_flag, m_flag[TSD]);
        chk("R9 not_ready", not_ready, m_nrdy);
        chk("R3/R4/R5/R6/R8/R9 drv_off", drv_off, exp_off());
        chk("R10 no_err", no_err, exp_no_err());
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    function automatic logic flip(logic v, int den);
        return (($urandom % den) == 0) ? !v : v;
    endfunction

    initial begin
        int unsigned seed_ignore;
        seed_ignore = $urandom(32'd9431);
        rst_n = 0; active = 0; clr_stb = 0; rcv_dis = 0;
        raw_ol = '0; raw_ov = 0; raw_uv = 0; raw_tw = 0; raw_tsd = 0;
        steps(3);
        chk("R8 reset drv_off", drv_off, 1);
        chk("R10 reset no_err", no_err, 1);
        rst_n = 1; active = 1;
        step();
        chk("R9 not_ready after start", not_ready, 1);
        steps(SETTLE);
        chk("R9 not_ready self-clears", not_ready, 0);
        chk("R9 drv_off released", drv_off, 0);

        // R1 short pulse is rejected
        raw_ov = 1; steps(FAST - 1); raw_ov = 0; step();
        chk("R1 short pulse ov_flag", ov_flag, 0);

        // R7 clear on the qualifying edge: set wins
        raw_ov = 1; steps(FAST - 1); clr_stb = 1; step(); clr_stb = 0;
        chk("R7 set beats clear", ov_flag, 1);
        raw_ov = 0; step();

        // R4 thermal shutdown: clear refused while raw high
        raw_tsd = 1; steps(FAST);
        chk("R4 tsd drv_off", drv_off, 1);
        clr_stb = 1; step(); clr_stb = 0;
        chk("R4 clear refused", tsd_flag, 1);
        raw_tsd = 0; step();
        clr_stb = 1; step(); clr_stb = 0;
        chk("R4 clear accepted", tsd_flag, 0);
        chk("R7 ov cleared", ov_flag, 0);

        // R6 manual recovery
        rcv_dis = 1; raw_uv = 1; steps(FAST); raw_uv = 0; step();
        chk("R6 off held by flag", drv_off, 1);
        clr_stb = 1; step(); clr_stb = 0;
        chk("R6 off released by clear", drv_off, 0);

        // R5 automatic recovery
        rcv_dis = 0; raw_ov = 1; steps(FAST);
        chk("R5 off while live", drv_off, 1);
        raw_ov = 0; step();
        chk("R5 off released", drv_off, 0);
        chk("R5 flag kept", ov_flag, 1);
        clr_stb = 1; step(); clr_stb = 0;

        // R3 informational faults
        raw_tw = 1; raw_ol = '1; steps(SLOW);
        chk("R3 ol flags", ol_flag, {NCH{1'b1}});
        chk("R3 tw flag", tw_flag, 1);
        chk("R3 no disable", drv_off, 0);
        chk("R10 no_err low", no_err, 0);

        // R8 standby clears
        active = 0; step();
        chk("R8 standby drv_off", drv_off, 1);
        chk("R8 flags cleared", {ol_flag, tw_flag}, 0);
        raw_tw = 0; raw_ol = '0; active = 1; steps(SETTLE + 1);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            step();
            for (int c = 0; c < NCH; c++) raw_ol[c] = flip(raw_ol[c], 14);
            raw_ov  = flip(raw_ov, 5);
            raw_uv  = flip(raw_uv, 6);
            raw_tw  = flip(raw_tw, 4);
            raw_tsd = flip(raw_tsd, 7);
            clr_stb = (($urandom % 9) == 0);
            rcv_dis = flip(rcv_dis, 150);
            active  = active ? (($urandom % 400) != 0) : (($urandom % 3) == 0);
        end
        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule